// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block steps a programmable logic device from power-up, or from a fresh program request, to normal operation. An active-low program request input throws the sequencer back into a memory-wipe phase. In that phase it drives a clear strobe and an address counter that sweeps every location of the configuration store, one address per cycle. When the sweep ends, an init-ready flag rises. The block then accepts configuration words over a valid/ready stream and hands each one to the store with a write strobe and a word index.

Once the expected number of words has arrived, the sequencer issues a one-cycle global reset pulse so that every flip-flop returns to its initial value. It then raises the done flag. Last, it lets go of two holds: the output-disable hold, which keeps pins tristated, and the state-freeze hold, which keeps flip-flops from changing. The two low bits of the first configuration word choose the order and spacing of these final releases. A program request in any phase aborts the run and starts the wipe again.

Top module: `cfg_startup_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, init_rdy and done are 0, io_hold and ff_hold are 1, and the wipe is under way at clr_addr 0 with no program request needed.
- R2: While prog_n is low, clr_en is 0 and the sweep is held at its start. With prog_n high, clr_en is 1 and clr_addr steps through 0 to CLEAR_CYCLES-1, one address per cycle.
- R3: init_rdy rises on the cycle after the last clear address. It is 0 for the whole sweep. s_ready is 1 only from that point until the last word is taken.
- R4: A word is taken in every cycle in which s_valid and s_ready are both 1. In that cycle ld_we is 1, ld_data equals s_data, and ld_addr counts 0, 1, 2 and so on. Idle cycles are allowed between words. s_valid during the wipe or after loading gives no ld_we.
- R5: glb_rst is 1 for exactly one cycle, the cycle after the LOAD_WORDS-th word is taken.
- R6: done rises on the cycle after the glb_rst pulse and stays 1 until the next program request.
- R7: Bits [1:0] of word 0 set the release order. With 00 or 11, io_hold drops one cycle after done rises and ff_hold drops one cycle after that. With 01, ff_hold drops first and io_hold drops one cycle later, with the same spacing. With 10, io_hold and ff_hold both drop in the cycle done rises.
- R8: While done is 0, io_hold and ff_hold are both 1.
- R9: prog_n low at a clock edge in any phase gives, from the next cycle on: done 0, init_rdy 0, s_ready 0, io_hold 1, ff_hold 1. When prog_n returns high, the sweep restarts at address 0 and the word index restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low program request, synchronous |
| clr_en | output | 1 | Wipe strobe for the configuration store |
| clr_addr | output | CW | Address being wiped |
| init_rdy | output | 1 | Wipe finished, ready for data |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Sequencer accepts stream words |
| ld_we | output | 1 | Write strobe for a configuration word |
| ld_addr | output | WW | Index of the word being written |
| ld_data | output | DATA_W | Word being written |
| glb_rst | output | 1 | One-cycle global set/reset pulse |
| done | output | 1 | Configuration complete |
| io_hold | output | 1 | Output tristate hold, 1 = pins released to high impedance |
| ff_hold | output | 1 | Flip-flop write-protect hold, 1 = state frozen |

## Verification
The full startup runs once for each of the four option codes, and each code is combined with gaps of zero, one and two idle cycles between stream words. Together these separate the three release orders, show that the 11 code falls back to the default order, and show that stream stalls neither lose nor repeat a word index. Aborts are applied in the middle of the wipe, in the middle of the load and after the run is complete. These show that the sweep address, the word index and the holds all return to their starting values. Stream words offered during the wipe confirm that nothing is written before init-ready.

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
  parameter int CLEAR_CYCLES = 64,
  parameter int LOAD_WORDS   = 16,
  parameter int DATA_W       = 16,
  localparam int CW = (CLEAR_CYCLES > 1) ? $clog2(CLEAR_CYCLES) : 1,
  localparam int WW = (LOAD_WORDS > 1) ? $clog2(LOAD_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n,
  output logic              clr_en,
  output logic [CW-1:0]     clr_addr,
  output logic              init_rdy,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              ld_we,
  output logic [WW-1:0]     ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              glb_rst,
  output logic              done,
  output logic              io_hold,
  output logic              ff_hold
);

  typedef enum logic [2:0] {
    ST_WIPE, ST_LOAD, ST_GRST, ST_REL_A, ST_REL_B, ST_RUN
  } phase_t;

  localparam logic [CW-1:0] CLR_LAST  = CW'(CLEAR_CYCLES - 1);
  localparam logic [WW-1:0] WORD_LAST = WW'(LOAD_WORDS - 1);

  phase_t        phase;
  logic [CW-1:0] clr_cnt;
  logic [WW-1:0] widx;
  logic [1:0]    order;
  logic          take;
  logic          ff_first;

  assign clr_en   = (phase == ST_WIPE) && prog_n;
  assign clr_addr = clr_cnt;
  assign init_rdy = (phase != ST_WIPE);
  assign s_ready  = (phase == ST_LOAD);
  assign take     = s_ready && s_valid;
  assign ld_we    = take;
  assign ld_addr  = widx;
  assign ld_data  = s_data;
  assign glb_rst  = (phase == ST_GRST);
  assign done     = (phase == ST_REL_A) || (phase == ST_REL_B) || (phase == ST_RUN);
  assign ff_first = (order == 2'b01);
  assign io_hold  = !((phase == ST_RUN) || ((phase == ST_REL_B) && !ff_first));
  assign ff_hold  = !((phase == ST_RUN) || ((phase == ST_REL_B) && ff_first));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_WIPE;
      clr_cnt <= '0;
      widx    <= '0;
      order   <= 2'b00;
    end else if (!prog_n) begin
      phase   <= ST_WIPE;
      clr_cnt <= '0;
      widx    <= '0;
      order   <= 2'b00;
    end else begin
      case (phase)
        ST_WIPE: begin
          if (clr_cnt == CLR_LAST) begin
            clr_cnt <= '0;
            phase   <= ST_LOAD;
          end else begin
            clr_cnt <= clr_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (take) begin
            if (widx == '0) order <= s_data[1:0];
            if (widx == WORD_LAST) begin
              widx  <= '0;
              phase <= ST_GRST;
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        ST_GRST:  phase <= (order == 2'b10) ? ST_RUN : ST_REL_A;
        ST_REL_A: phase <= ST_REL_B;
        ST_REL_B: phase <= ST_RUN;
        ST_RUN:   phase <= ST_RUN;
        default:  phase <= ST_WIPE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_startup_seq_chk.sv
module cfg_startup_seq_chk #(
  parameter int CW = 6,
  parameter int WW = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_n,
  input logic              clr_en,
  input logic [CW-1:0]     clr_addr,
  input logic              init_rdy,
  input logic              s_valid,
  input logic              s_ready,
  input logic              ld_we,
  input logic              glb_rst,
  input logic              done,
  input logic              io_hold,
  input logic              ff_hold
);

  a_r2_wipe_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_addr != '0) |-> $past(clr_en));

  a_r3_init_after_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_rdy) |-> $past(clr_en));

  a_r3_no_init_in_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !init_rdy);

  a_r4_write_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> (init_rdy && s_ready && s_valid));

  a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    glb_rst |=> !glb_rst);

  a_r6_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(glb_rst));

  a_r7_io_then_ff: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(io_hold) && ff_hold && prog_n) |=> !ff_hold);

  a_r7_ff_then_io: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ff_hold) && io_hold && prog_n) |=> !io_hold);

  a_r7_first_release_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(io_hold) && ff_hold) |-> $past(done));

  a_r8_holds_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (io_hold && ff_hold));

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (!done && !init_rdy && !s_ready && io_hold && ff_hold));

endmodule

bind cfg_startup_seq cfg_startup_seq_chk #(.CW(CW), .WW(WW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .clr_en(clr_en), .clr_addr(clr_addr),
  .init_rdy(init_rdy), .s_valid(s_valid), .s_ready(s_ready), .ld_we(ld_we),
  .glb_rst(glb_rst), .done(done), .io_hold(io_hold), .ff_hold(ff_hold)
);

// File: tb/tb_cfg_startup_seq.sv
module tb_cfg_startup_seq;
  localparam int CC = 6;
  localparam int LW = 5;
  localparam int DW = 8;
  localparam int CW = $clog2(CC);
  localparam int WW = $clog2(LW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_n = 1'b1;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic clr_en, init_rdy, s_ready, ld_we, glb_rst, done, io_hold, ff_hold;
  logic [CW-1:0] clr_addr;
  logic [WW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cfg_startup_seq #(.CLEAR_CYCLES(CC), .LOAD_WORDS(LW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .clr_en(clr_en), .clr_addr(clr_addr),
    .init_rdy(init_rdy), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .glb_rst(glb_rst),
    .done(done), .io_hold(io_hold), .ff_hold(ff_hold)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_held(input string req);
    chk(req, "done", done, 0);
    chk(req, "init_rdy", init_rdy, 0);
    chk(req, "s_ready", s_ready, 0);
    chk(req, "io_hold", io_hold, 1);
    chk(req, "ff_hold", ff_hold, 1);
  endtask

  task automatic do_wipe(input int upto);
    s_valid = 1'b1;
    s_data  = 8'hA5;
    for (int k = 0; k < upto; k++) begin
      #1;
      chk("R2", "clr_en", clr_en, 1);
      chk("R2", "clr_addr", clr_addr, k);
      chk("R3", "init_rdy in wipe", init_rdy, 0);
      chk("R4", "ld_we in wipe", ld_we, 0);
      chk("R8", "holds in wipe", io_hold & ff_hold, 1);
      @(negedge clk);
    end
    s_valid = 1'b0;
    if (upto == CC) begin
      #1;
      chk("R3", "init_rdy after wipe", init_rdy, 1);
      chk("R3", "s_ready after wipe", s_ready, 1);
      chk("R2", "clr_en after wipe", clr_en, 0);
    end
  endtask

  task automatic do_abort;
    prog_n = 1'b0;
    #1;
    chk("R2", "clr_en while prog low", clr_en, 0);
    @(negedge clk);
    chk_held("R9");
    @(negedge clk);
    chk_held("R9");
    chk("R2", "addr held at 0", clr_addr, 0);
    prog_n = 1'b1;
  endtask

  task automatic do_load(input int opt, input int gap, input int nwords);
    for (int w = 0; w < nwords; w++) begin
      logic [DW-1:0] d;
      for (int g = 0; g < gap; g++) begin
        s_valid = 1'b0;
        #1;
        chk("R4", "ld_we in gap", ld_we, 0);
        chk("R5", "glb_rst in load", glb_rst, 0);
        @(negedge clk);
      end
      d = DW'(w * 53 + 7 + opt * 11);
      if (w == 0) d[1:0] = opt[1:0];
      s_valid = 1'b1;
      s_data  = d;
      #1;
      chk("R4", "ld_we", ld_we, 1);
      chk("R4", "ld_addr", ld_addr, w);
      chk("R4", "ld_data", ld_data, d);
      chk("R8", "holds in load", io_hold & ff_hold, 1);
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic do_release(input int opt);
    int ie, fe;
    chk("R5", "glb_rst pulse", glb_rst, 1);
    chk("R8", "done during pulse", done, 0);
    chk("R8", "holds during pulse", io_hold & ff_hold, 1);
    s_valid = 1'b1;
    #1;
    chk("R4", "ld_we after load", ld_we, 0);
    @(negedge clk);
    for (int c = 1; c <= 5; c++) begin
      if (opt == 2) begin ie = 0; fe = 0; end
      else if (c == 1) begin ie = 1; fe = 1; end
      else if (c == 2) begin ie = (opt == 1) ? 1 : 0; fe = (opt == 1) ? 0 : 1; end
      else begin ie = 0; fe = 0; end
      chk("R5", "glb_rst after pulse", glb_rst, 0);
      chk("R6", "done", done, 1);
      chk("R7", $sformatf("io_hold opt%0d c%0d", opt, c), io_hold, ie);
      chk("R7", $sformatf("ff_hold opt%0d c%0d", opt, c), ff_hold, fe);
      chk("R4", "ld_we in run", ld_we, 0);
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk_held("R1");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_held("R1");
    chk("R1", "clr_en at start", clr_en, 1);
    chk("R1", "clr_addr at start", clr_addr, 0);
    do_wipe(CC);
    do_load(0, 0, LW);
    do_release(0);

    for (int opt = 0; opt < 4; opt++) begin
      for (int gap = 0; gap < 3; gap++) begin
        do_abort();
        do_wipe(CC);
        do_load(opt, gap, LW);
        do_release(opt);
      end
    end

    do_abort();
    do_wipe(3);
    do_abort();
    do_wipe(CC);
    do_load(2, 1, 2);
    do_abort();
    do_wipe(CC);
    do_load(1, 0, LW);
    do_release(1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule